// File: doc/BRIEF.md
# Device Status Wait Engine

This engine sits on the host side of a storage device register interface. It waits for the device to finish its current operation and then waits for a chosen set of status bits to appear. After a start pulse it polls the device's alternate status byte over a simple strobe-and-valid register port. It counts elapsed time in microsecond ticks and finishes with a one-cycle done pulse, a result byte and the last status byte it read.

The work runs in two phases. In the first phase the engine waits for the busy bit to drop. Polling is fast at first and slows once the early part of the time budget has been used. A status of all ones means that nothing drives the bus. In that case the engine reselects the requested unit and charges a large time penalty. In the second phase, which runs only for a nonzero mask, the engine polls a fixed number of times at a fixed interval until every mask bit reads as one. Each phase has its own failure code, so the caller can tell a device that never became idle from one that became idle but never showed the wanted bits.

Top module: `dev_status_waiter`

## Requirements
- R1: After reset, done, reg_rd and reg_wr are low, and result and last_status are 0x00.
- R2: A start pulse in idle arms a settle delay of SETTLE_US ticks, followed by a read of status address STS_ADDR. Only one read is outstanding at a time. A read may take any number of cycles before reg_rvalid returns its data, and reg_rd and reg_wr are never high in the same cycle.
- R3: When a busy-phase read returns a status with bit 7 (busy) set, the engine waits before the next read and adds the wait to its spent time. The wait is FAST_STEP_US while spent time is at most FAST_LIMIT_US, and SLOW_STEP_US after that.
- R4: A status of 0xFF causes one write of 0xA0 with the latched unit number in bit 4 to address DRV_ADDR. FLOAT_PENALTY_US is then added to the spent time and waited before the next read.
- R5: A check before each busy-phase read compares the spent time with BUSY_BUDGET_US. If spent time has reached the budget, the engine makes no more reads and finishes with result 0xFE. Every result is one of 0x00, 0x01, 0xFE or 0xFD.
- R6: With a zero mask, the engine finishes on the first status with bit 7 clear. The result is that status's bit 0 (error).
- R7: With a nonzero mask, the engine waits SETTLE_US once busy clears. It then reads up to MASK_POLLS times, MASK_STEP_US apart, and finishes on the first status where all mask bits are set. The result is that status's bit 0.
- R8: If none of the MASK_POLLS mask-phase reads match, the engine waits one more MASK_STEP_US and finishes with result 0xFD.
- R9: Done is high for exactly one cycle per run, and result changes only in a cycle where done is high.
- R10: A start pulse while a run is in progress has no effect. It does not change the latched mask or unit, and it does not start a second run.
- R11: last_status holds the byte returned by the final read of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| start | input | 1 | Begin a run (ignored unless idle) |
| want_mask | input | 8 | Status bits that must all read one in the second phase |
| unit | input | 1 | Device number used for reselection |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_addr | output | AW | Register address for the current strobe |
| reg_wdata | output | 8 | Write data |
| reg_rvalid | input | 1 | Read data valid |
| reg_rdata | input | 8 | Read data |
| done | output | 1 | Run finished, one-cycle pulse |
| result | output | 8 | 0x00/0x01 error bit, 0xFE busy timeout, 0xFD mask timeout |
| last_status | output | 8 | Last status byte read |

## Verification
A scripted device model returns a sequence of bus-floating reads, then busy reads, then non-matching reads, then a final status. The sweep steps the number of busy reads through the fast-to-slow boundary and into budget exhaustion, which shows whether the interval switch happens at the right spent time. It also steps the number of floating reads, which tests the reselect write and penalty accounting against both units. Single-bit masks against a fixed status separate the match path from the mask timeout. The tick gap measured between consecutive reads is compared with the expected interval at every step, and the read latency is varied so the valid handshake is exercised.

// File: rtl/dsw_pkg.sv
// Shared constants and state type for the device status wait engine.
// Assumes an 8-bit status byte with busy in bit 7 and error in bit 0.
package dsw_pkg;

    localparam logic [7:0] FLOAT_STATUS  = 8'hFF;
    localparam logic [7:0] RES_BUSY_TMO  = 8'hFE;
    localparam logic [7:0] RES_MASK_TMO  = 8'hFD;
    localparam logic [7:0] DRV_SEL_BASE  = 8'hA0;
    localparam int         STS_BUSY_BIT  = 7;
    localparam int         STS_ERR_BIT   = 0;
    localparam int         DRV_UNIT_BIT  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY_WAIT,
        ST_BUSY_READ,
        ST_MASK_WAIT,
        ST_MASK_READ
    } dsw_state_t;

    // Larger of two integers, used to size counters.
    function automatic int dsw_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsw_delay.sv
// Microsecond delay: counts a loaded number of us_tick pulses.
// Assumes load_val >= 1. expire is high in the cycle of the final tick.
module dsw_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);

    logic [W-1:0] cnt;
    logic         running;

    // Load a new count or step it down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            running <= (load_val != '0);
        end else if (running && tick) begin
            cnt <= cnt - W'(1);
            if (cnt == W'(1)) begin
                running <= 1'b0;
            end
        end
    end

    // Final tick of the loaded interval.
    assign expire = running && tick && (cnt == W'(1));

endmodule

// File: rtl/dsw_budget.sv
// Spent-time accumulator for the busy phase.
// Assumes steps are added only while the total is below the budget.
module dsw_budget #(
    parameter int W          = 21,
    parameter int BUDGET     = 1000000,
    parameter int FAST_LIMIT = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] step,
    output logic         exhausted,
    output logic         past_fast
);

    logic [W-1:0] spent;

    // Clear at the start of a run and accumulate charged time.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            spent <= '0;
        end else if (add) begin
            spent <= spent + step;
        end
    end

    // Comparisons against the configured limits.
    assign exhausted = (spent >= W'(BUDGET));
    assign past_fast = (spent >  W'(FAST_LIMIT));

endmodule

// File: rtl/dsw_bus_access.sv
// Register port sequencer: turns read/write requests into one-cycle
// strobes and waits for reg_rvalid on reads. One read outstanding at a time.
module dsw_bus_access #(
    parameter int              AW       = 4,
    parameter logic [AW-1:0]   RD_ADDR  = '0,
    parameter logic [AW-1:0]   WR_ADDR  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic [7:0]    wr_data,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata,
    input  logic          reg_rvalid,
    input  logic [7:0]    reg_rdata,
    output logic          rd_done,
    output logic [7:0]    rd_data
);

    logic pending;

    // Register strobes, address and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            reg_rd <= rd_go;
            reg_wr <= wr_go;
            if (wr_go) begin
                reg_addr  <= WR_ADDR;
                reg_wdata <= wr_data;
            end else if (rd_go) begin
                reg_addr  <= RD_ADDR;
            end
        end
    end

    // Track the outstanding read until its data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (rd_go) begin
            pending <= 1'b1;
        end else if (reg_rvalid) begin
            pending <= 1'b0;
        end
    end

    assign rd_done = pending && reg_rvalid;
    assign rd_data = reg_rdata;

endmodule

// File: rtl/dev_status_waiter.sv
// Device status wait engine, top level.
// Waits for busy to clear with adaptive polling and a time budget, then
// optionally waits for all bits of a mask. Assumes every *_US parameter
// is at least 1 and that us_tick is a one-cycle pulse.
module dev_status_waiter
    import dsw_pkg::*;
#(
    parameter int            AW               = 4,
    parameter logic [AW-1:0] STS_ADDR         = 4'hE,
    parameter logic [AW-1:0] DRV_ADDR         = 4'h6,
    parameter int            SETTLE_US        = 1,
    parameter int            FAST_STEP_US     = 10,
    parameter int            SLOW_STEP_US     = 1000,
    parameter int            FAST_LIMIT_US    = 1000,
    parameter int            FLOAT_PENALTY_US = 1000,
    parameter int            BUSY_BUDGET_US   = 1000000,
    parameter int            MASK_STEP_US     = 10,
    parameter int            MASK_POLLS       = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick,
    input  logic          start,
    input  logic [7:0]    want_mask,
    input  logic          unit,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata,
    input  logic          reg_rvalid,
    input  logic [7:0]    reg_rdata,
    output logic          done,
    output logic [7:0]    result,
    output logic [7:0]    last_status
);

    localparam int MAX_BUSY_STEP = dsw_max(dsw_max(FAST_STEP_US, SLOW_STEP_US), FLOAT_PENALTY_US);
    localparam int MAX_DELAY     = dsw_max(dsw_max(MAX_BUSY_STEP, SETTLE_US), MASK_STEP_US);
    localparam int DLY_W         = $clog2(MAX_DELAY + 1);
    localparam int BUD_W         = $clog2(BUSY_BUDGET_US + MAX_BUSY_STEP + 1);
    localparam int POLL_W        = $clog2(MASK_POLLS + 1);

    dsw_state_t  st, nxt;
    logic [7:0]  mask_q;
    logic        unit_q;
    logic [POLL_W-1:0] polls_left;

    logic             rd_go, wr_go, rd_done;
    logic [7:0]       rd_data, sel_value;
    logic             dly_load, dly_expire;
    logic [DLY_W-1:0] dly_val;
    logic             bud_clr, bud_add, bud_exhausted, bud_past_fast;
    logic [BUD_W-1:0] bud_step;
    logic             fin, poll_load, poll_dec;
    logic [7:0]       fin_code;

    assign sel_value = DRV_SEL_BASE | (8'(unit_q) << DRV_UNIT_BIT);

    dsw_delay #(.W(DLY_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .tick     (us_tick),
        .expire   (dly_expire)
    );

    dsw_budget #(
        .W          (BUD_W),
        .BUDGET     (BUSY_BUDGET_US),
        .FAST_LIMIT (FAST_LIMIT_US)
    ) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bud_clr),
        .add       (bud_add),
        .step      (bud_step),
        .exhausted (bud_exhausted),
        .past_fast (bud_past_fast)
    );

    dsw_bus_access #(
        .AW      (AW),
        .RD_ADDR (STS_ADDR),
        .WR_ADDR (DRV_ADDR)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_go      (rd_go),
        .wr_go      (wr_go),
        .wr_data    (sel_value),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rvalid (reg_rvalid),
        .reg_rdata  (reg_rdata),
        .rd_done    (rd_done),
        .rd_data    (rd_data)
    );

    // Next-state and control decode for both wait phases.
    always_comb begin
        nxt       = st;
        rd_go     = 1'b0;
        wr_go     = 1'b0;
        dly_load  = 1'b0;
        dly_val   = '0;
        bud_clr   = 1'b0;
        bud_add   = 1'b0;
        bud_step  = '0;
        fin       = 1'b0;
        fin_code  = '0;
        poll_load = 1'b0;
        poll_dec  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    bud_clr  = 1'b1;
                    dly_load = 1'b1;
                    dly_val  = DLY_W'(SETTLE_US);
                    nxt      = ST_BUSY_WAIT;
                end
            end
            ST_BUSY_WAIT: begin
                if (dly_expire) begin
                    if (bud_exhausted) begin
                        fin      = 1'b1;
                        fin_code = RES_BUSY_TMO;
                        nxt      = ST_IDLE;
                    end else begin
                        rd_go = 1'b1;
                        nxt   = ST_BUSY_READ;
                    end
                end
            end
            ST_BUSY_READ: begin
                if (rd_done) begin
                    if (rd_data == FLOAT_STATUS) begin
                        wr_go    = 1'b1;
                        bud_add  = 1'b1;
                        bud_step = BUD_W'(FLOAT_PENALTY_US);
                        dly_load = 1'b1;
                        dly_val  = DLY_W'(FLOAT_PENALTY_US);
                        nxt      = ST_BUSY_WAIT;
                    end else if (!rd_data[STS_BUSY_BIT]) begin
                        if (mask_q == '0) begin
                            fin      = 1'b1;
                            fin_code = {7'd0, rd_data[STS_ERR_BIT]};
                            nxt      = ST_IDLE;
                        end else begin
                            dly_load  = 1'b1;
                            dly_val   = DLY_W'(SETTLE_US);
                            poll_load = 1'b1;
                            nxt       = ST_MASK_WAIT;
                        end
                    end else begin
                        bud_add  = 1'b1;
                        dly_load = 1'b1;
                        if (bud_past_fast) begin
                            bud_step = BUD_W'(SLOW_STEP_US);
                            dly_val  = DLY_W'(SLOW_STEP_US);
                        end else begin
                            bud_step = BUD_W'(FAST_STEP_US);
                            dly_val  = DLY_W'(FAST_STEP_US);
                        end
                        nxt = ST_BUSY_WAIT;
                    end
                end
            end
            ST_MASK_WAIT: begin
                if (dly_expire) begin
                    if (polls_left == '0) begin
                        fin      = 1'b1;
                        fin_code = RES_MASK_TMO;
                        nxt      = ST_IDLE;
                    end else begin
                        rd_go = 1'b1;
                        nxt   = ST_MASK_READ;
                    end
                end
            end
            ST_MASK_READ: begin
                if (rd_done) begin
                    if ((rd_data & mask_q) == mask_q) begin
                        fin      = 1'b1;
                        fin_code = {7'd0, rd_data[STS_ERR_BIT]};
                        nxt      = ST_IDLE;
                    end else begin
                        poll_dec = 1'b1;
                        dly_load = 1'b1;
                        dly_val  = DLY_W'(MASK_STEP_US);
                        nxt      = ST_MASK_WAIT;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Latch the request when a run starts in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            unit_q <= 1'b0;
        end else if (st == ST_IDLE && start) begin
            mask_q <= want_mask;
            unit_q <= unit;
        end
    end

    // Remaining mask-phase read count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            polls_left <= '0;
        end else if (poll_load) begin
            polls_left <= POLL_W'(MASK_POLLS);
        end else if (poll_dec) begin
            polls_left <= polls_left - POLL_W'(1);
        end
    end

    // Completion pulse and held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= fin;
            if (fin) result <= fin_code;
        end
    end

    // Capture every returned status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_status <= '0;
        end else if (rd_done) begin
            last_status <= rd_data;
        end
    end

endmodule

// File: rtl/dsw_checker.sv
// Protocol and result checks for the device status wait engine.
module dsw_checker #(
    parameter int            AW       = 4,
    parameter logic [AW-1:0] DRV_ADDR = 4'h6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          done,
    input logic [7:0]    result
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));                                   // R9
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_addr == DRV_ADDR && (reg_wdata & 8'hEF) == 8'hA0)); // R4
    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);                                          // R2
    AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));                                         // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == 8'h00 || result == 8'h01 ||
                  result == 8'hFE || result == 8'hFD));               // R5

endmodule

bind dev_status_waiter dsw_checker #(.AW(AW), .DRV_ADDR(DRV_ADDR)) u_dsw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .done      (done),
    .result    (result)
);

// File: tb/dev_status_waiter_bench.sv
`timescale 1ns/1ps
module dev_status_waiter_bench;

    localparam int            AW       = 4;
    localparam logic [AW-1:0] STS_ADDR = 4'hE;
    localparam logic [AW-1:0] DRV_ADDR = 4'h6;
    localparam int SETTLE = 1, FAST = 2, SLOW = 8, FLIM = 10, PEN = 8;
    localparam int BUDGET = 60, MSTEP = 3, POLLS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_tick = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    want_mask = '0;
    logic          unit = 1'b0;
    logic          reg_rd, reg_wr;
    logic [AW-1:0] reg_addr;
    logic [7:0]    reg_wdata;
    logic          reg_rvalid;
    logic [7:0]    reg_rdata;
    logic          done;
    logic [7:0]    result, last_status;

    always #10 clk = ~clk;

    dev_status_waiter #(
        .AW(AW), .STS_ADDR(STS_ADDR), .DRV_ADDR(DRV_ADDR),
        .SETTLE_US(SETTLE), .FAST_STEP_US(FAST), .SLOW_STEP_US(SLOW),
        .FAST_LIMIT_US(FLIM), .FLOAT_PENALTY_US(PEN), .BUSY_BUDGET_US(BUDGET),
        .MASK_STEP_US(MSTEP), .MASK_POLLS(POLLS)
    ) u_dev_status_waiter (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
        .want_mask(want_mask), .unit(unit), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .done(done), .result(result),
        .last_status(last_status)
    );

    // Scripted device configuration.
    int         cf_float, cf_busy, cf_part, cf_lat, run_base;
    logic [7:0] cf_pv, cf_fv;

    function automatic logic [7:0] dev_status(input int i);
        if (i < cf_float)                   return 8'hFF;
        if (i < cf_float + cf_busy)         return 8'h80;
        if (i < cf_float + cf_busy + cf_part) return cf_pv;
        return cf_fv;
    endfunction

    // Device model: answers each read after cf_lat+1 cycles.
    int  dev_total = 0;
    int  dcnt = 0;
    bit  dpend = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            dpend      <= 0;
            reg_rvalid <= 1'b0;
            reg_rdata  <= 8'h00;
        end else begin
            reg_rvalid <= 1'b0;
            if (dpend) begin
                if (dcnt <= 1) begin
                    reg_rvalid <= 1'b1;
                    reg_rdata  <= dev_status(dev_total - run_base);
                    dev_total  <= dev_total + 1;
                    dpend      <= 0;
                end else begin
                    dcnt <= dcnt - 1;
                end
            end
            if (reg_rd) begin
                dpend <= 1;
                dcnt  <= cf_lat;
            end
        end
    end

    // Tick source: one pulse every four cycles.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            us_tick = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    // Monitor, sampled mid-cycle.
    int tick_cnt = 0, rd_total = 0, wr_total = 0, wr_bad = 0, done_total = 0;
    int stamps [0:8191];
    always @(negedge clk) begin
        if (us_tick) tick_cnt = tick_cnt + 1;
        if (reg_rd) begin
            stamps[rd_total % 8192] = tick_cnt;
            rd_total = rd_total + 1;
        end
        if (reg_wr) begin
            wr_total = wr_total + 1;
            if (reg_addr != DRV_ADDR || reg_wdata != (8'hA0 | (8'(unit) << 4)))
                wr_bad = wr_bad + 1;
        end
        if (done) done_total = done_total + 1;
    end

    int n_chk = 0, n_fail = 0;
    bit hung = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected behaviour derived from the requirements.
    int         e_reads, e_writes;
    logic [7:0] e_res, e_last;
    int         e_gap [0:127];

    task automatic model(input logic [7:0] mk);
        int spent = 0, n = 0;
        bit idle_seen = 0, hit = 0;
        logic [7:0] s = 8'h00;
        e_writes = 0;
        while (spent < BUDGET) begin
            s = dev_status(n);
            n++;
            if (s == 8'hFF) begin
                e_writes++;
                e_gap[n] = PEN;
                spent += PEN;
                continue;
            end
            if (!s[7]) begin
                idle_seen = 1;
                break;
            end
            e_gap[n] = (spent > FLIM) ? SLOW : FAST;
            spent += e_gap[n];
        end
        if (!idle_seen) begin
            e_res = 8'hFE;
        end else if (mk == 8'h00) begin
            e_res = {7'd0, s[0]};
        end else begin
            e_gap[n] = SETTLE;
            for (int k = 0; k < POLLS; k++) begin
                s = dev_status(n);
                n++;
                if ((s & mk) == mk) begin
                    hit = 1;
                    break;
                end
                e_gap[n] = MSTEP;
            end
            e_res = hit ? {7'd0, s[0]} : 8'hFD;
        end
        e_last  = s;
        e_reads = n;
    endtask

    task automatic run_case(input int nf, input int nb, input int np,
                            input logic [7:0] pv, input logic [7:0] fv,
                            input logic [7:0] mk, input logic un,
                            input int lat, input bit poke, input bit hold,
                            input string req);
        int rd0, wr0, bad0, dn0, cyc, gap_bad;
        logic [7:0] res_seen;
        if (hung) return;
        cf_float = nf; cf_busy = nb; cf_part = np; cf_pv = pv; cf_fv = fv;
        cf_lat = lat;
        @(negedge clk);
        run_base  = dev_total;
        rd0 = rd_total; wr0 = wr_total; bad0 = wr_bad; dn0 = done_total;
        want_mask = mk;
        unit      = un;
        model(mk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            want_mask = 8'h00;
            start     = 1'b1;
            @(negedge clk);
            start     = 1'b0;
        end
        cyc = 0;
        while (done_total == dn0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (done_total == dn0) begin
            chk(0, "R9", "watchdog expired waiting for done", 0, 1);
            hung = 1;
            return;
        end
        repeat (4) @(negedge clk);
        chk(result == e_res, req, "result", result, e_res);
        chk(last_status == e_last, "R11", "last_status", last_status, e_last);
        chk(rd_total - rd0 == e_reads, req, "read count", rd_total - rd0, e_reads);
        chk(wr_total - wr0 == e_writes, "R4", "reselect writes", wr_total - wr0, e_writes);
        chk(wr_bad == bad0, "R4", "reselect address/data errors", wr_bad - bad0, 0);
        chk(done_total - dn0 == 1, poke ? "R10" : "R9", "done pulses",
            done_total - dn0, 1);
        gap_bad = 0;
        for (int i = 1; i < e_reads && i < 128; i++) begin
            int g = stamps[(rd0 + i) % 8192] - stamps[(rd0 + i - 1) % 8192];
            if (g < e_gap[i] || g > e_gap[i] + 1) gap_bad++;
        end
        chk(gap_bad == 0, "R3", "read intervals outside expected window", gap_bad, 0);
        if (hold) begin
            res_seen = result;
            repeat (30) @(negedge clk);
            chk(result == res_seen, "R9", "result held after done", result, res_seen);
            chk(rd_total - rd0 == e_reads, "R9", "no reads after done", rd_total - rd0, e_reads);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(reg_rd == 1'b0 && reg_wr == 1'b0, "R1", "strobes after reset", reg_rd | reg_wr, 0);
        chk(result == 8'h00, "R1", "result after reset", result, 0);
        chk(last_status == 8'h00, "R1", "last_status after reset", last_status, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: zero mask, idle at once, error clear and set
        run_case(0, 0, 0, 8'h00, 8'h50, 8'h00, 1'b0, 1, 0, 1, "R6");
        run_case(0, 0, 0, 8'h00, 8'h51, 8'h00, 1'b1, 2, 0, 0, "R6");
        // R2: slow read latency, short busy
        run_case(0, 3, 0, 8'h00, 8'h58, 8'h48, 1'b0, 3, 0, 0, "R2");
        // R5: busy never clears
        run_case(0, 1000, 0, 8'h00, 8'h50, 8'h00, 1'b0, 1, 0, 1, "R5");
        // R10: second start during a long run
        run_case(0, 1000, 0, 8'h00, 8'h50, 8'h40, 1'b1, 2, 1, 0, "R10");
        // R4: floating bus then ready
        run_case(2, 1, 0, 8'h00, 8'h40, 8'h40, 1'b1, 1, 0, 0, "R4");
        run_case(1000, 0, 0, 8'h00, 8'h40, 8'h00, 1'b0, 2, 0, 0, "R5");
        // R8: mask never matches
        run_case(0, 0, 0, 8'h00, 8'h40, 8'h48, 1'b0, 1, 0, 1, "R8");
        // R7: mismatching reads then match with error set
        run_case(0, 2, 2, 8'h40, 8'h49, 8'h48, 1'b0, 2, 0, 0, "R7");
        run_case(0, 0, 4, 8'h40, 8'h49, 8'h48, 1'b1, 3, 0, 0, "R7");

        // R3: sweep busy length across the fast/slow switch and the budget
        for (int nb = 0; nb <= 14; nb++)
            for (int u = 0; u < 2; u++)
                run_case(0, nb, 0, 8'h00, 8'h50, 8'h00, u[0], 1 + (nb % 3), 0, 0, "R3");
        // R4: sweep floating reads, mixed with busy
        for (int nf = 0; nf <= 8; nf++)
            run_case(nf, nf % 3, 0, 8'h00, 8'h50, 8'h10, nf[0], 1 + (nf % 3), 0, 0, "R4");
        // R7/R8: single-bit masks against status 0x55
        for (int b = 0; b < 7; b++)
            run_case(0, 1, 0, 8'h00, 8'h55, 8'(1 << b), 1'b0, 1 + (b % 3), 0, 0,
                     ((8'h55 >> b) & 1) ? "R7" : "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule